// File: doc/BRIEF.md
# Sectored Data-Cache Tag and Coherency Directory

This block keeps the tags and per-line coherency states of a direct-mapped, sectored data cache. Each of the 64 directory entries covers a 64-byte sector made of two 32-byte lines. The two lines share one address tag, and each line carries its own MESI state. A tag match is therefore not enough for a hit: the addressed line must also be valid. Replacing a sector discards both of its lines.

Three request ports act on the directory in the same cycle:

- **Processor lookup port.** It reports hit or miss for the addressed line. On a write hit it upgrades an Exclusive line to Modified. On a write hit to a Shared line it asks for a bus write.
- **Fill port.** It installs a line after a miss. It either reuses the sector's tag, or it reallocates the whole sector and raises write-back requests for any Modified line it displaces.
- **Snoop port.** It handles external inquiries. A snoop either downgrades the line to Shared or invalidates it, and it flags a hit on a dirty line.

All results are registered and appear one cycle after the request.

Top module: `sector_dir`

## Requirements
- R1: An address splits into tag = bits 31:12, entry index = bits 11:6, line select = bit 5 (0 = lower line, 1 = upper line). Bits 4:0 are byte offset and never change any result.
- R2: After synchronous reset every line of every entry is Invalid, so every lookup misses. States are encoded on `rsp_state` as Invalid = 2'b00, Shared = 2'b01, Exclusive = 2'b10, Modified = 2'b11.
- R3: A lookup hits only when the tag matches and the addressed line is not Invalid. `rsp_state` reports the addressed line's state seen by the lookup when the tag matches, and 2'b00 otherwise. A miss changes no state.
- R4: `rsp_valid`, `rsp_hit`, `rsp_state` and `rsp_bus_wr` appear exactly one cycle after `cpu_req`. `rsp_valid` is low in cycles that follow no request.
- R5: A write hit on an Exclusive line leaves it Modified. A write hit on a Modified line keeps it Modified. A read hit leaves the state unchanged.
- R6: A write hit on a Shared line raises `rsp_bus_wr` and leaves the line Shared. `rsp_bus_wr` is low for every other lookup.
- R7: A fill installs the line as Exclusive when `fill_shared` is 0 and as Shared when it is 1.
- R8: A fill whose tag matches the entry changes only the filled line. The tag and the sibling line keep their values.
- R9: A fill whose tag differs from the entry's tag writes the new tag and sets the sibling line Invalid. One cycle later, `wb_mask` bit i is set for each line i that was Modified, with `wb_tag` giving the old tag and `wb_idx` the entry. `wb_mask` is 0 when no Modified line is displaced.
- R10: A snoop that hits a Modified line raises `snp_dirty` one cycle later. The line then becomes Invalid when `snp_inval` = 1 and Shared when `snp_inval` = 0.
- R11: A snoop that hits an Exclusive or Shared line moves it to Invalid when `snp_inval` = 1 and to Shared when `snp_inval` = 0. `snp_hit` reports the hit one cycle later. A snoop to a mismatching tag or an Invalid line reports no hit and changes nothing.
- R12: Requests in the same cycle apply in order: snoop first, then fill, then lookup. A lookup to the entry a snoop touches in the same cycle sees, and reports, the post-snoop state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor lookup request |
| cpu_wr | input | 1 | Lookup is a write |
| cpu_addr | input | 32 | Lookup physical address |
| fill_req | input | 1 | Line fill request |
| fill_shared | input | 1 | Another cache holds the filled line |
| fill_addr | input | 32 | Fill physical address |
| snp_req | input | 1 | External snoop inquiry |
| snp_inval | input | 1 | 1 = invalidate, 0 = share inquiry |
| snp_addr | input | 32 | Snoop physical address |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_state | output | 2 | Addressed line's state seen by the lookup |
| rsp_bus_wr | output | 1 | Write hit on a Shared line needs a bus write |
| snp_hit | output | 1 | Snoop hit a valid line |
| snp_dirty | output | 1 | Snoop hit a Modified line; write-back needed |
| wb_mask | output | 2 | Lines displaced while Modified by a reallocating fill |
| wb_tag | output | 20 | Tag of the displaced sector |
| wb_idx | output | 6 | Entry index of the displaced sector |

## Verification
The hardest situation to reach from the ports is a reallocating fill that displaces two Modified lines at once. Both lines of one sector must first be brought to Modified through a fill and a write each, and only then is a fill with a new tag sent. The second hard case is same-cycle contention, where a snoop and a processor write or read land on the same line in one cycle. The bench drives both requests on the same clock edge and then reads the line back to confirm the ordered result. Around these cases it sweeps every entry, both lines and both fill sharing modes, and every valid starting state against each snoop kind and each access kind.

// File: rtl/sdir_pkg.sv
package sdir_pkg;

    parameter int ADDR_W  = 32;
    parameter int BYTE_LG = 5;
    parameter int LINE_LG = 1;
    parameter int SET_LG  = 6;

    localparam int LINES  = 1 << LINE_LG;
    localparam int SETS   = 1 << SET_LG;
    localparam int IDX_LO = BYTE_LG + LINE_LG;
    localparam int TAG_LO = IDX_LO + SET_LG;
    localparam int TAG_W  = ADDR_W - TAG_LO;

    typedef enum logic [1:0] {
        ST_INV = 2'b00,
        ST_SHR = 2'b01,
        ST_EXC = 2'b10,
        ST_MOD = 2'b11
    } mesi_t;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [TAG_W-1:0]   tag_t;
    typedef logic [SET_LG-1:0]  idx_t;
    typedef logic [LINE_LG-1:0] lsel_t;
    typedef logic [LINES-1:0]   lmask_t;

    typedef struct packed {
        tag_t                tag;
        mesi_t [LINES-1:0]   st;
    } sect_t;

    function automatic tag_t a_tag(input addr_t a);
        return a[ADDR_W-1:TAG_LO];
    endfunction

    function automatic idx_t a_idx(input addr_t a);
        return a[TAG_LO-1:IDX_LO];
    endfunction

    function automatic lsel_t a_line(input addr_t a);
        return a[IDX_LO-1:BYTE_LG];
    endfunction

endpackage

// File: rtl/sdir_snoop.sv
module sdir_snoop
    import sdir_pkg::*;
(
    input  logic  valid,
    input  logic  inval,
    input  tag_t  tag,
    input  lsel_t line,
    input  sect_t cur,
    output sect_t nxt,
    output logic  hit,
    output logic  dirty
);
    always_comb begin
        nxt   = cur;
        hit   = valid && (cur.tag == tag) && (cur.st[line] != ST_INV);
        dirty = hit && (cur.st[line] == ST_MOD);
        if (hit) begin
            if (inval) nxt.st[line] = ST_INV;
            else       nxt.st[line] = ST_SHR;
        end
    end
endmodule

// File: rtl/sdir_fill.sv
module sdir_fill
    import sdir_pkg::*;
(
    input  logic   valid,
    input  logic   shared,
    input  tag_t   tag,
    input  lsel_t  line,
    input  sect_t  cur,
    output sect_t  nxt,
    output lmask_t wb_mask
);
    logic match;

    always_comb begin
        nxt     = cur;
        wb_mask = '0;
        match   = (cur.tag == tag);
        if (valid) begin
            if (!match) begin
                // reallocation: every line of the old sector is displaced
                nxt.tag = tag;
                for (int i = 0; i < LINES; i++) begin
                    wb_mask[i] = (cur.st[i] == ST_MOD);
                    nxt.st[i]  = ST_INV;
                end
            end else begin
                wb_mask[line] = (cur.st[line] == ST_MOD);
            end
            if (shared) nxt.st[line] = ST_SHR;
            else        nxt.st[line] = ST_EXC;
        end
    end
endmodule

// File: rtl/sdir_lookup.sv
module sdir_lookup
    import sdir_pkg::*;
(
    input  logic  valid,
    input  logic  write,
    input  tag_t  tag,
    input  lsel_t line,
    input  sect_t cur,
    output sect_t nxt,
    output logic  hit,
    output logic  bus_wr,
    output mesi_t state
);
    logic match;

    always_comb begin
        nxt    = cur;
        match  = (cur.tag == tag);
        state  = match ? cur.st[line] : ST_INV;
        hit    = valid && match && (cur.st[line] != ST_INV);
        bus_wr = hit && write && (cur.st[line] == ST_SHR);
        if (hit && write && (cur.st[line] == ST_EXC))
            nxt.st[line] = ST_MOD;
    end
endmodule

// File: rtl/sector_dir.sv
module sector_dir
    import sdir_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              fill_req,
    input  logic              fill_shared,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              snp_req,
    input  logic              snp_inval,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [1:0]        rsp_state,
    output logic              rsp_bus_wr,
    output logic              snp_hit,
    output logic              snp_dirty,
    output logic [LINES-1:0]  wb_mask,
    output logic [TAG_W-1:0]  wb_tag,
    output logic [SET_LG-1:0] wb_idx
);
    sect_t dir_q [SETS];

    idx_t  c_idx, f_idx, s_idx;
    lsel_t c_line, f_line, s_line;

    assign c_idx  = a_idx(cpu_addr);
    assign f_idx  = a_idx(fill_addr);
    assign s_idx  = a_idx(snp_addr);
    assign c_line = a_line(cpu_addr);
    assign f_line = a_line(fill_addr);
    assign s_line = a_line(snp_addr);

    logic unused_byte_bits;
    assign unused_byte_bits = ^{cpu_addr[BYTE_LG-1:0], fill_addr[BYTE_LG-1:0],
                                snp_addr[BYTE_LG-1:0]};

    // ---- ordered chain: snoop, then fill, then lookup ----
    sect_t  snp_cur, snp_nxt, fill_cur, fill_nxt, lk_cur, lk_nxt;
    logic   snp_hit_c, snp_dirty_c, lk_hit, lk_bus_wr;
    mesi_t  lk_state;
    lmask_t fill_wb;

    assign snp_cur  = dir_q[s_idx];
    assign fill_cur = (snp_req && s_idx == f_idx) ? snp_nxt : dir_q[f_idx];

    always_comb begin
        if (fill_req && f_idx == c_idx)      lk_cur = fill_nxt;
        else if (snp_req && s_idx == c_idx)  lk_cur = snp_nxt;
        else                                 lk_cur = dir_q[c_idx];
    end

    sdir_snoop u_snp (
        .valid (snp_req),
        .inval (snp_inval),
        .tag   (a_tag(snp_addr)),
        .line  (s_line),
        .cur   (snp_cur),
        .nxt   (snp_nxt),
        .hit   (snp_hit_c),
        .dirty (snp_dirty_c)
    );

    sdir_fill u_fill (
        .valid   (fill_req),
        .shared  (fill_shared),
        .tag     (a_tag(fill_addr)),
        .line    (f_line),
        .cur     (fill_cur),
        .nxt     (fill_nxt),
        .wb_mask (fill_wb)
    );

    sdir_lookup u_lk (
        .valid  (cpu_req),
        .write  (cpu_wr),
        .tag    (a_tag(cpu_addr)),
        .line   (c_line),
        .cur    (lk_cur),
        .nxt    (lk_nxt),
        .hit    (lk_hit),
        .bus_wr (lk_bus_wr),
        .state  (lk_state)
    );

    // ---- directory storage: later writes carry earlier effects ----
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SETS; i++) dir_q[i] <= '0;
        end else begin
            if (snp_req)  dir_q[s_idx] <= snp_nxt;
            if (fill_req) dir_q[f_idx] <= fill_nxt;
            if (cpu_req)  dir_q[c_idx] <= lk_nxt;
        end
    end

    // ---- registered results ----
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_state  <= ST_INV;
            rsp_bus_wr <= 1'b0;
            snp_hit    <= 1'b0;
            snp_dirty  <= 1'b0;
            wb_mask    <= '0;
            wb_tag     <= '0;
            wb_idx     <= '0;
        end else begin
            rsp_valid  <= cpu_req;
            rsp_hit    <= lk_hit;
            rsp_state  <= cpu_req ? lk_state : ST_INV;
            rsp_bus_wr <= lk_bus_wr;
            snp_hit    <= snp_hit_c;
            snp_dirty  <= snp_dirty_c;
            wb_mask    <= fill_wb;
            wb_tag     <= fill_cur.tag;
            wb_idx     <= f_idx;
        end
    end

    // ---- assertions ----
    idx_t  chk_cidx_q, chk_sidx_q;
    lsel_t chk_cline_q, chk_sline_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            chk_cidx_q  <= '0;
            chk_sidx_q  <= '0;
            chk_cline_q <= '0;
            chk_sline_q <= '0;
        end else begin
            chk_cidx_q  <= c_idx;
            chk_sidx_q  <= s_idx;
            chk_cline_q <= c_line;
            chk_sline_q <= s_line;
        end
    end

    a_r4_rsp_after_req: assert property (@(posedge clk) disable iff (rst)
        cpu_req |=> rsp_valid);

    a_r4_no_rsp_without_req: assert property (@(posedge clk) disable iff (rst)
        !cpu_req |=> !rsp_valid && !rsp_hit);

    a_r3_hit_has_valid_state: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_state != ST_INV);

    a_r6_buswr_on_shared_hit: assert property (@(posedge clk) disable iff (rst)
        rsp_bus_wr |-> rsp_hit && rsp_state == ST_SHR);

    a_r10_dirty_is_hit: assert property (@(posedge clk) disable iff (rst)
        snp_dirty |-> snp_hit);

    a_r5_write_hit_modified: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_wr && lk_hit && lk_state != ST_SHR)
        |=> dir_q[chk_cidx_q].st[chk_cline_q] == ST_MOD);

    a_r11_inval_clears_line: assert property (@(posedge clk) disable iff (rst)
        (snp_req && snp_inval && snp_hit_c && !(fill_req && f_idx == s_idx))
        |=> dir_q[chk_sidx_q].st[chk_sline_q] == ST_INV);

    a_r9_wb_needs_fill: assert property (@(posedge clk) disable iff (rst)
        !fill_req |=> wb_mask == '0);

endmodule

// File: tb/sim_sector_dir.sv
module sim_sector_dir;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_req, cpu_wr, fill_req, fill_shared, snp_req, snp_inval;
    logic [31:0] cpu_addr, fill_addr, snp_addr;
    logic        rsp_valid, rsp_hit, rsp_bus_wr, snp_hit, snp_dirty;
    logic [1:0]  rsp_state, wb_mask;
    logic [19:0] wb_tag;
    logic [5:0]  wb_idx;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    sector_dir u0 (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .fill_req(fill_req), .fill_shared(fill_shared), .fill_addr(fill_addr),
        .snp_req(snp_req), .snp_inval(snp_inval), .snp_addr(snp_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_state(rsp_state),
        .rsp_bus_wr(rsp_bus_wr), .snp_hit(snp_hit), .snp_dirty(snp_dirty),
        .wb_mask(wb_mask), .wb_tag(wb_tag), .wb_idx(wb_idx)
    );

    function automatic logic [31:0] mk(input int tag, input int idx,
                                       input int line, input int byo);
        logic [19:0] t = tag[19:0];
        logic [5:0]  x = idx[5:0];
        return {t, x, line[0], byo[4:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
        cpu_req = 0; cpu_wr = 0; fill_req = 0; snp_req = 0;
    endtask

    task automatic lookup(input logic [31:0] a, input logic wr);
        @(negedge clk);
        cpu_req = 1; cpu_wr = wr; cpu_addr = a;
        settle();
    endtask

    task automatic fill(input logic [31:0] a, input logic sh);
        @(negedge clk);
        fill_req = 1; fill_shared = sh; fill_addr = a;
        settle();
    endtask

    task automatic snoop(input logic [31:0] a, input logic inv);
        @(negedge clk);
        snp_req = 1; snp_inval = inv; snp_addr = a;
        settle();
    endtask

    // state codes: 0 I, 1 S, 2 E, 3 M
    task automatic set_state(input logic [31:0] a, input int s);
        if (s != 0) begin
            fill(a, s == 1);
            if (s == 3) lookup(a, 1'b1);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst = 1;
        cpu_req = 0; cpu_wr = 0; cpu_addr = '0;
        fill_req = 0; fill_shared = 0; fill_addr = '0;
        snp_req = 0; snp_inval = 0; snp_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R2 / R4: every entry Invalid after reset
        for (int i = 0; i < 64; i++) begin
            lookup(mk(0, i, i % 2, 0), 1'b0);
            chk("R2 hit after reset", rsp_hit, 0);
            chk("R2 state after reset", rsp_state, 0);
            chk("R4 rsp_valid", rsp_valid, 1);
        end
        @(posedge clk); #1;
        chk("R4 no request no valid", rsp_valid, 0);

        // R7 / R1 / R3 / R9: fill sweep over all entries, lines and share modes
        for (int i = 0; i < 64; i++) begin
            fill(mk(i + 1, i, i % 2, 7), (i / 2) % 2);
            chk("R9 no wb on clean realloc", wb_mask, 0);
            lookup(mk(i + 1, i, i % 2, 31), 1'b0);
            chk("R7 R1 fill hit", rsp_hit, 1);
            chk("R7 fill state", rsp_state, ((i / 2) % 2) ? 1 : 2);
            lookup(mk(i + 1, i, 1 - (i % 2), 0), 1'b0);
            chk("R3 tag match invalid line miss", rsp_hit, 0);
            chk("R3 sibling state", rsp_state, 0);
        end

        // R10 / R11: every valid start state against both snoop kinds
        for (int s = 1; s <= 3; s++) begin
            for (int k = 0; k < 2; k++) begin
                automatic int idx = s * 2 + k;
                automatic logic [31:0] a = mk(100 + idx, idx, 0, 3);
                set_state(a, s);
                snoop(a, k[0]);
                chk(s == 3 ? "R10 snoop hit" : "R11 snoop hit", snp_hit, 1);
                chk(s == 3 ? "R10 snoop dirty" : "R11 snoop clean",
                    snp_dirty, (s == 3) ? 1 : 0);
                lookup(a, 1'b0);
                chk(s == 3 ? "R10 post-snoop state" : "R11 post-snoop state",
                    rsp_state, k ? 0 : 1);
                chk(s == 3 ? "R10 post-snoop hit" : "R11 post-snoop hit",
                    rsp_hit, k ? 0 : 1);
            end
        end

        // R5 / R6: write and read hits from every valid state
        for (int s = 1; s <= 3; s++) begin
            automatic int idx = 10 + s;
            automatic logic [31:0] a = mk(200 + idx, idx, 1, 9);
            set_state(a, s);
            lookup(a, 1'b1);
            chk("R5 write hit", rsp_hit, 1);
            chk("R6 bus write", rsp_bus_wr, (s == 1) ? 1 : 0);
            chk("R3 pre-write state", rsp_state, s);
            lookup(a, 1'b0);
            chk("R5 state after write", rsp_state, (s == 1) ? 1 : 3);
            chk("R6 read no bus write", rsp_bus_wr, 0);
            lookup(a, 1'b0);
            chk("R5 read keeps state", rsp_state, (s == 1) ? 1 : 3);
        end
        lookup(mk(200, 14, 0, 0), 1'b1);
        chk("R3 write miss", rsp_hit, 0);
        chk("R6 write miss no bus write", rsp_bus_wr, 0);
        lookup(mk(200, 14, 0, 0), 1'b0);
        chk("R3 miss changes nothing", rsp_state, 0);

        // R11: snoop misses
        set_state(mk(300, 20, 0, 0), 2);
        snoop(mk(301, 20, 0, 0), 1'b1);
        chk("R11 snoop tag miss", snp_hit, 0);
        snoop(mk(300, 20, 1, 0), 1'b1);
        chk("R11 snoop invalid line", snp_hit, 0);
        lookup(mk(300, 20, 0, 0), 1'b0);
        chk("R11 snoop miss keeps state", rsp_state, 2);

        // R8: line fill with matching tag
        set_state(mk(400, 21, 0, 0), 3);
        fill(mk(400, 21, 1, 0), 1'b0);
        chk("R8 no wb on line fill", wb_mask, 0);
        lookup(mk(400, 21, 0, 0), 1'b0);
        chk("R8 sibling kept", rsp_state, 3);
        lookup(mk(400, 21, 1, 0), 1'b0);
        chk("R8 filled line", rsp_state, 2);

        // R9: reallocation with both lines Modified
        set_state(mk(500, 22, 0, 0), 3);
        set_state(mk(500, 22, 1, 0), 3);
        fill(mk(501, 22, 1, 0), 1'b1);
        chk("R9 wb mask both", wb_mask, 2'b11);
        chk("R9 wb tag", wb_tag, 500);
        chk("R9 wb idx", wb_idx, 22);
        lookup(mk(500, 22, 0, 0), 1'b0);
        chk("R9 old tag gone", rsp_hit, 0);
        lookup(mk(501, 22, 0, 0), 1'b0);
        chk("R9 sibling invalid", rsp_state, 0);
        lookup(mk(501, 22, 1, 0), 1'b0);
        chk("R9 filled shared", rsp_state, 1);

        // R9: one Modified line displaced
        set_state(mk(510, 23, 0, 0), 3);
        set_state(mk(510, 23, 1, 0), 2);
        fill(mk(511, 23, 0, 0), 1'b0);
        chk("R9 wb mask single", wb_mask, 2'b01);
        chk("R9 wb idx single", wb_idx, 23);

        // R12: snoop share and write on an Exclusive line in one cycle
        set_state(mk(600, 24, 0, 0), 2);
        @(negedge clk);
        snp_req = 1; snp_inval = 0; snp_addr = mk(600, 24, 0, 0);
        cpu_req = 1; cpu_wr = 1; cpu_addr = mk(600, 24, 0, 4);
        settle();
        chk("R12 write sees post-snoop", rsp_state, 1);
        chk("R12 bus write", rsp_bus_wr, 1);
        chk("R12 snoop hit", snp_hit, 1);
        lookup(mk(600, 24, 0, 0), 1'b0);
        chk("R12 final state", rsp_state, 1);

        // R12: invalidate and read one line in one cycle
        set_state(mk(601, 25, 1, 0), 1);
        @(negedge clk);
        snp_req = 1; snp_inval = 1; snp_addr = mk(601, 25, 1, 0);
        cpu_req = 1; cpu_wr = 0; cpu_addr = mk(601, 25, 1, 0);
        settle();
        chk("R12 read after inval miss", rsp_hit, 0);
        chk("R12 inval snoop hit", snp_hit, 1);

        summary();
        $finish;
    end
endmodule